// File: doc/BRIEF.md
# Programmable CRC-32 Register Engine

This block is a CRC-32 calculator that software drives through a small 32-bit register bus. Software stores a seed and a 32-bit generator polynomial, then issues a load command that copies the seed into the running checksum. After that, every 32-bit word written to the data register advances the checksum by one full word in a single clock cycle. Reading the data register returns the running checksum at any point between words and leaves it unchanged.

Three control bits turn on bit reflection together. In that mode each input word is bit-reversed across all 32 bits before it is processed, and the value read back is bit-reversed too. Bus words are byte streams in little-endian order. With reflection on, the normal (non-reflected) polynomials 0x04C11DB7 and 0x1EDC6F41 give the reflected CRC-32 and CRC-32C checksums. The engine applies no final complement; software adds it.

The bus uses a valid/ready request channel. A request transfers on a rising edge where `bus_valid` and `bus_ready` are both high. The master must keep `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` steady until that edge. The engine pulls `bus_ready` low for one cycle after each accepted data-register write. Reads give a one-cycle `rsp_valid` pulse with `rsp_rdata` in the cycle after acceptance. There is no back-pressure on the response.

Top module: `crc32_regs`

## Requirements
- R1: After reset, control reads 0x00000000, seed reads 0xFFFFFFFF, polynomial reads 0x04C11DB7, and the data register reads 0xFFFFFFFF.
- R2: A write to the data register (offset 0x00) replaces the running CRC with the value found by taking the 32 input bits MSB first. For each bit: the feedback is the state's bit 31 XOR the input bit; the state shifts left by one; if the feedback is 1 the polynomial is XORed into the state. No final inversion is applied.
- R3: When control bits 7, 6 and 5 are all 1, the input word is bit-reversed before the R2 update and the data register reads back bit-reversed. With any of these three bits at 0, the engine runs non-reflected.
- R4: Writing control (offset 0x08) with bit 0 set loads the seed register into the running CRC. Control bit 0 always reads 0. Bits 7..5 read back as last written, and all other control bits read 0.
- R5: Writes to the seed (offset 0x10) or polynomial (offset 0x14) register read back as written and leave the running CRC unchanged. A new seed only takes effect at the next load command. The polynomial in use is always the current polynomial register.
- R6: Reading any register leaves the running CRC unchanged, so repeated reads of the data register return the same value.
- R7: `bus_ready` is low for exactly the one cycle after an accepted data-register write and high at all other times after reset.
- R8: Each accepted read gives exactly one `rsp_valid` pulse, one cycle later, carrying the selected register value on `rsp_rdata`.
- R9: With reflection on, seed 0xFFFFFFFF and polynomial 0x04C11DB7 (or 0x1EDC6F41), the complemented readback equals the standard CRC-32 (or CRC-32C) of the little-endian byte stream that was written.
- R10: Offsets other than 0x00, 0x08, 0x10 and 0x14 read 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Engine can accept a request |
| rsp_valid | output | 1 | Read data valid, one cycle after read acceptance |
| rsp_rdata | output | 32 | Read data |

## Verification
A data write is accepted on edge T and has updated the CRC by that same edge. `bus_ready` is low in the cycle after T, so the earliest following request transfers on edge T+2. A read accepted on edge T shows `rsp_valid` and its data in the cycle after T. The bench drives inputs on falling edges, samples `bus_ready` before committing a request, and samples the read response on the falling edge right after the acceptance edge. It also checks that `bus_ready` is low at the first falling edge after a data write and high again at the next one.

// File: rtl/crc32_regs_pkg.sv
package crc32_regs_pkg;
  localparam logic [7:0] OFS_DATA = 8'h00;
  localparam logic [7:0] OFS_CTRL = 8'h08;
  localparam logic [7:0] OFS_SEED = 8'h10;
  localparam logic [7:0] OFS_POLY = 8'h14;

  localparam int CTL_LOAD_BIT = 0;
  localparam int CTL_REFL_LO  = 5;
  localparam int CTL_REFL_HI  = 7;
  localparam int CTL_REFL_W   = CTL_REFL_HI - CTL_REFL_LO + 1;

  typedef enum logic [2:0] {
    SEL_DATA,
    SEL_CTRL,
    SEL_SEED,
    SEL_POLY,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/crc32_bus_port.sv
module crc32_bus_port
  import crc32_regs_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              bus_ready,
  output logic              wr_data,
  output logic              wr_ctrl,
  output logic              wr_seed,
  output logic              wr_poly,
  input  logic [DW-1:0]     view_data,
  input  logic [DW-1:0]     view_ctrl,
  input  logic [DW-1:0]     view_seed,
  input  logic [DW-1:0]     view_poly,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata
);
  logic     busy_q;
  logic     accept;
  reg_sel_e sel;

  assign bus_ready = ~busy_q;
  assign accept    = bus_valid & bus_ready;

  always_comb begin
    if (bus_addr == OFS_DATA[ADDR_W-1:0])      sel = SEL_DATA;
    else if (bus_addr == OFS_CTRL[ADDR_W-1:0]) sel = SEL_CTRL;
    else if (bus_addr == OFS_SEED[ADDR_W-1:0]) sel = SEL_SEED;
    else if (bus_addr == OFS_POLY[ADDR_W-1:0]) sel = SEL_POLY;
    else                                       sel = SEL_NONE;
  end

  assign wr_data = accept & bus_write & (sel == SEL_DATA);
  assign wr_ctrl = accept & bus_write & (sel == SEL_CTRL);
  assign wr_seed = accept & bus_write & (sel == SEL_SEED);
  assign wr_poly = accept & bus_write & (sel == SEL_POLY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept & ~bus_write;
      if (accept && !bus_write) begin
        unique case (sel)
          SEL_DATA: rsp_rdata <= view_data;
          SEL_CTRL: rsp_rdata <= view_ctrl;
          SEL_SEED: rsp_rdata <= view_seed;
          SEL_POLY: rsp_rdata <= view_poly;
          default:  rsp_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/crc32_cfg_regs.sv
module crc32_cfg_regs
  import crc32_regs_pkg::*;
#(
  parameter int              DW       = 32,
  parameter logic [DW-1:0]   SEED_RST = '1,
  parameter logic [DW-1:0]   POLY_RST = 32'h04C11DB7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_seed,
  input  logic          wr_poly,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] seed_q,
  output logic [DW-1:0] poly_q,
  output logic          load_pulse,
  output logic          reflect,
  output logic [DW-1:0] view_ctrl
);
  logic [CTL_REFL_W-1:0] refl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_q <= SEED_RST;
      poly_q <= POLY_RST;
      refl_q <= '0;
    end else begin
      if (wr_seed) seed_q <= wdata;
      if (wr_poly) poly_q <= wdata;
      if (wr_ctrl) refl_q <= wdata[CTL_REFL_HI:CTL_REFL_LO];
    end
  end

  assign load_pulse = wr_ctrl & wdata[CTL_LOAD_BIT];
  assign reflect    = &refl_q;

  always_comb begin
    view_ctrl = '0;
    view_ctrl[CTL_REFL_HI:CTL_REFL_LO] = refl_q;
  end
endmodule

// File: rtl/crc32_step.sv
module crc32_step #(
  parameter int            DW       = 32,
  parameter logic [DW-1:0] SEED_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          load,
  input  logic          reflect,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] seed,
  input  logic [DW-1:0] poly,
  output logic [DW-1:0] state,
  output logic [DW-1:0] view
);
  logic [DW-1:0] din_rev;
  logic [DW-1:0] state_rev;
  logic [DW-1:0] feed;
  logic [DW-1:0] nxt;

  for (genvar g = 0; g < DW; g++) begin : g_rev
    assign din_rev[g]   = din[DW-1-g];
    assign state_rev[g] = state[DW-1-g];
  end

  assign feed = reflect ? din_rev : din;
  assign view = reflect ? state_rev : state;

  always_comb begin
    logic fb;
    nxt = state;
    for (int i = DW - 1; i >= 0; i--) begin
      fb  = nxt[DW-1] ^ feed[i];
      nxt = {nxt[DW-2:0], 1'b0};
      if (fb) nxt = nxt ^ poly;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= SEED_RST;
    else if (load)    state <= seed;
    else if (advance) state <= nxt;
  end
endmodule

// File: rtl/crc32_regs.sv
module crc32_regs #(
  parameter int            ADDR_W   = 5,
  parameter int            DW       = 32,
  parameter logic [DW-1:0] SEED_RST = '1,
  parameter logic [DW-1:0] POLY_RST = 32'h04C11DB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic              bus_ready,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata
);
  logic          wr_data, wr_ctrl, wr_seed, wr_poly;
  logic [DW-1:0] seed_q, poly_q, view_ctrl, crc_q, view_data;
  logic          load_pulse, reflect;

  crc32_bus_port #(.ADDR_W(ADDR_W), .DW(DW)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_ready (bus_ready),
    .wr_data   (wr_data),
    .wr_ctrl   (wr_ctrl),
    .wr_seed   (wr_seed),
    .wr_poly   (wr_poly),
    .view_data (view_data),
    .view_ctrl (view_ctrl),
    .view_seed (seed_q),
    .view_poly (poly_q),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  crc32_cfg_regs #(.DW(DW), .SEED_RST(SEED_RST), .POLY_RST(POLY_RST)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wr_ctrl),
    .wr_seed    (wr_seed),
    .wr_poly    (wr_poly),
    .wdata      (bus_wdata),
    .seed_q     (seed_q),
    .poly_q     (poly_q),
    .load_pulse (load_pulse),
    .reflect    (reflect),
    .view_ctrl  (view_ctrl)
  );

  crc32_step #(.DW(DW), .SEED_RST(SEED_RST)) u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (wr_data),
    .load    (load_pulse),
    .reflect (reflect),
    .din     (bus_wdata),
    .seed    (seed_q),
    .poly    (poly_q),
    .state   (crc_q),
    .view    (view_data)
  );
endmodule

// File: rtl/crc32_regs_chk.sv
module crc32_regs_chk
  import crc32_regs_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              bus_ready,
  input logic              rsp_valid,
  input logic [DW-1:0]     rsp_rdata,
  input logic [DW-1:0]     crc_state
);
  logic acc, acc_rd, acc_wdata, acc_load, rd_ctrl;
  assign acc       = bus_valid & bus_ready;
  assign acc_rd    = acc & ~bus_write;
  assign acc_wdata = acc & bus_write & (bus_addr == OFS_DATA[ADDR_W-1:0]);
  assign acc_load  = acc & bus_write & (bus_addr == OFS_CTRL[ADDR_W-1:0]) & bus_wdata[CTL_LOAD_BIT];
  assign rd_ctrl   = acc_rd & (bus_addr == OFS_CTRL[ADDR_W-1:0]);

  // R7: one stall cycle after a data write
  a_r7_stall_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wdata |=> !bus_ready);
  // R7: stall never lasts more than one cycle
  a_r7_stall_single: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |=> bus_ready);
  // R8: read acceptance yields a response next cycle
  a_r8_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rsp_valid);
  // R8: no response without a read
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> !rsp_valid);
  // R5 and R6: state moves only on a data write or a load command
  a_r6_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_wdata && !acc_load) |=> $stable(crc_state));
  // R4: load bit reads as zero
  a_r4_load_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |=> !rsp_rdata[CTL_LOAD_BIT]);
endmodule

bind crc32_regs crc32_regs_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_ready (bus_ready),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .crc_state (crc_q)
);

// File: tb/sim_crc32_regs.sv
`timescale 1ns/1ps
module sim_crc32_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int total = 0;
  int bad = 0;

  // model state
  logic [31:0] m_crc, m_seed, m_poly;
  logic        m_refl;

  always #4 clk = ~clk;

  crc32_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic logic [31:0] word_step(input logic [31:0] c, input logic [31:0] w,
                                            input logic [31:0] p, input logic refl);
    logic [31:0] d;
    d = refl ? rev32(w) : w;
    for (int i = 31; i >= 0; i--) begin
      if (c[31] ^ d[i]) c = (c << 1) ^ p;
      else              c = c << 1;
    end
    return c;
  endfunction

  // reflected, byte-at-a-time reference (LSB first)
  function automatic logic [31:0] byte_ref(input logic [31:0] c, input logic [7:0] b,
                                           input logic [31:0] rp);
    c = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ rp) : (c >> 1);
    return c;
  endfunction

  function automatic logic [31:0] view(input logic [31:0] c, input logic refl);
    return refl ? rev32(c) : c;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    while (!bus_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    if (a == 5'h00) begin
      check("R7 ready low after data write", {31'd0, bus_ready}, 32'd0);
      m_crc = word_step(m_crc, d, m_poly, m_refl);
    end else if (a == 5'h08) begin
      m_refl = &d[7:5];
      if (d[0]) m_crc = m_seed;
    end else if (a == 5'h10) m_seed = d;
    else if (a == 5'h14) m_poly = d;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] q);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    while (!bus_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    check("R8 rsp_valid after read", {31'd0, rsp_valid}, 32'd1);
    q = rsp_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] q, q2, ref_c;
    logic [7:0]  msg [0:8];
    void'($urandom(32'd20240611));
    m_crc = 32'hFFFFFFFF; m_seed = 32'hFFFFFFFF; m_poly = 32'h04C11DB7; m_refl = 1'b0;
    msg[0] = "1"; msg[1] = "2"; msg[2] = "3"; msg[3] = "4"; msg[4] = "5";
    msg[5] = "6"; msg[6] = "7"; msg[7] = "8"; msg[8] = "9";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 ready high after reset", {31'd0, bus_ready}, 32'd1);
    check("R8 no response at idle", {31'd0, rsp_valid}, 32'd0);

    // R1 reset values
    bus_rd(5'h08, q); check("R1 ctrl reset", q, 32'h0);
    bus_rd(5'h10, q); check("R1 seed reset", q, 32'hFFFFFFFF);
    bus_rd(5'h14, q); check("R1 poly reset", q, 32'h04C11DB7);
    bus_rd(5'h00, q); check("R1 data reset", q, 32'hFFFFFFFF);

    // R2 plain update, R6 repeated read
    bus_wr(5'h00, 32'h12345678);
    @(negedge clk);
    check("R7 ready back high", {31'd0, bus_ready}, 32'd1);
    bus_rd(5'h00, q);  check("R2 plain word", q, m_crc);
    @(negedge clk);
    check("R8 single response pulse", {31'd0, rsp_valid}, 32'd0);
    bus_rd(5'h00, q2); check("R6 repeat read stable", q2, q);

    // R5 seed/poly writes do not disturb state
    bus_wr(5'h10, 32'hA5A5A5A5);
    bus_wr(5'h14, 32'h1EDC6F41);
    bus_rd(5'h00, q);  check("R5 state kept after seed/poly write", q, m_crc);
    bus_rd(5'h10, q);  check("R5 seed readback", q, 32'hA5A5A5A5);
    bus_rd(5'h14, q);  check("R5 poly readback", q, 32'h1EDC6F41);
    bus_wr(5'h00, 32'hDEADBEEF);
    bus_rd(5'h00, q);  check("R5 new poly in use", q, m_crc);

    // R4 load + partial reflection bits (R3: stays plain)
    bus_wr(5'h08, 32'h0000_0021);
    bus_rd(5'h08, q);  check("R4 ctrl readback", q, 32'h0000_0020);
    bus_rd(5'h00, q);  check("R4 load seed", q, 32'hA5A5A5A5);
    bus_wr(5'h00, 32'h0F0F1234);
    bus_rd(5'h00, q);  check("R3 partial bits stay plain", q, m_crc);
    bus_wr(5'h08, 32'hFFFF_FF7E);
    bus_rd(5'h08, q);  check("R4 only bits 7..5 kept", q, 32'h0000_0060);
    bus_rd(5'h00, q);  check("R4 no load without bit 0", q, m_crc);

    // R10 unmapped offsets
    bus_wr(5'h04, 32'h11111111);
    bus_wr(5'h0C, 32'h22222222);
    bus_wr(5'h1C, 32'h33333333);
    bus_rd(5'h04, q);  check("R10 unmapped 0x04 reads 0", q, 32'h0);
    bus_rd(5'h0C, q);  check("R10 unmapped 0x0C reads 0", q, 32'h0);
    bus_rd(5'h00, q);  check("R10 data untouched", q, m_crc);
    bus_rd(5'h10, q);  check("R10 seed untouched", q, 32'hA5A5A5A5);
    bus_rd(5'h14, q);  check("R10 poly untouched", q, 32'h1EDC6F41);

    // R9 reference model self-test on "123456789"
    ref_c = 32'hFFFFFFFF;
    for (int i = 0; i < 9; i++) ref_c = byte_ref(ref_c, msg[i], rev32(32'h04C11DB7));
    check("R9 model crc32 check value", ~ref_c, 32'hCBF43926);
    ref_c = 32'hFFFFFFFF;
    for (int i = 0; i < 9; i++) ref_c = byte_ref(ref_c, msg[i], rev32(32'h1EDC6F41));
    check("R9 model crc32c check value", ~ref_c, 32'hE3069283);

    // R9 / R3 engine against byte model on "12345678"
    for (int v = 0; v < 2; v++) begin
      logic [31:0] p;
      p = (v == 0) ? 32'h04C11DB7 : 32'h1EDC6F41;
      bus_wr(5'h10, 32'hFFFFFFFF);
      bus_wr(5'h14, p);
      bus_wr(5'h08, 32'h0000_00E1);
      bus_wr(5'h00, {msg[3], msg[2], msg[1], msg[0]});
      bus_wr(5'h00, {msg[7], msg[6], msg[5], msg[4]});
      bus_rd(5'h00, q);
      ref_c = 32'hFFFFFFFF;
      for (int i = 0; i < 8; i++) ref_c = byte_ref(ref_c, msg[i], rev32(p));
      check(v == 0 ? "R9 crc32 engine" : "R9 crc32c engine", ~q, ~ref_c);
      check("R3 reflected model", q, view(m_crc, m_refl));
    end

    // random mix (R2 R3 R4 R5 R6)
    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0: bus_wr(5'h10, $urandom());
        1: bus_wr(5'h14, $urandom() | 32'h1);
        2: bus_wr(5'h08, $urandom() & 32'h0000_00E1);
        3: bus_wr(5'h08, ($urandom_range(0, 1) != 0) ? 32'hE1 : 32'h01);
        default: bus_wr(5'h00, $urandom());
      endcase
      if ($urandom_range(0, 2) == 0) begin
        bus_rd(5'h00, q);
        check("R2 R3 random readback", q, view(m_crc, m_refl));
      end
    end
    bus_rd(5'h00, q);
    check("R2 R3 random final", q, view(m_crc, m_refl));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule